// File: doc/BRIEF.md
# One-Time-Programmable Byte Write Sequencer

This block carries out the two write transactions of a small one-time-programmable store. One is for a paged user data array and one is for a short status array. A bit-level front end hands it whole bytes from the master: a command byte, a 16-bit start address sent low byte first, and then one data byte at a time. It hands a byte back whenever the master spends eight read slots. For each data byte the sequencer first returns a CRC-8 of what it received. It then waits for a single-cycle strobe that stands for a valid programming pulse. It stores the old byte ANDed with the new data, so bits only ever move from 1 to 0. It then returns the stored byte so the master can confirm it.

After the readback the master may send the next data byte without a bus reset. The address then steps forward by one, and the CRC for that byte is seeded with the new low address byte. A cleared bit in status byte 0 write-protects the matching data page. Addresses past the end of the target array are never programmed and read back as all-ones. A bus reset abandons the transaction at any point.

Top module: `otpw_seq`

## Requirements
- R1: In the idle state, the first received byte selects the transaction. 0x0F targets the data array (PAGES x PAGE_BYTES bytes, erased to 0xFF). 0x55 targets the status array (STAT_BYTES bytes, erased to 0xFF). Any other value makes the block ignore every byte, request and strobe until a bus reset, and it gives no `tx_valid`.
- R2: After the command, the next received byte is address bits 7:0, the byte after that is bits 15:8, and the one after that is the first data byte. The first `tx_req` after the data byte returns a CRC-8 over the command, the address low byte, the address high byte and the data byte, in that order. The CRC uses polynomial x^8+x^5+x^4+1, is shifted LSB first and starts from 0x00.
- R3: A `prog_strobe` that arrives after the CRC has been returned stores (old byte AND data byte) at the current address.
- R4: The `tx_req` after the strobe returns the byte now stored at the current address.
- R5: If `tx_req` arrives while the block waits for a strobe, nothing is written, and the current stored byte is returned.
- R6: After a readback, the next data byte applies to the address plus one. Its CRC covers only that data byte, starting from the new low address byte.
- R7: A 0 in bit n of status byte 0 locks data page n, where the page number is address bits 6:5 with the default sizes. A strobe on a locked page leaves the byte unchanged, and the readback shows the unchanged value. The status array is never locked.
- R8: An address at or beyond the end of the target array is never programmed and reads back as 0xFF. Continuing from such an address does not increment it any further, so the next CRC seed stays that address's low byte.
- R9: `bus_reset` returns the block to idle from any state. A strobe or a `tx_req` after it has no effect until a new command arrives.
- R10: `tx_valid` is high for exactly the one cycle after an accepted `tx_req`, and `tx_byte` is valid in that cycle. At all other times, including after reset, `tx_valid` is low.
- R11: A stored bit that is 0 never returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer; stored bytes are kept |
| bus_reset | input | 1 | Master reset pulse; aborts the transaction |
| rx_valid | input | 1 | A byte from the master is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master wants a byte (eight read slots) |
| prog_strobe | input | 1 | One-cycle stand-in for a valid programming pulse |
| tx_valid | output | 1 | `tx_byte` holds the requested byte |
| tx_byte | output | 8 | Byte returned to the master, CRC or readback |

## Verification
Several properties are checked on every cycle. A response appears only the cycle after a request. A bus reset suppresses the next response. An unknown command keeps the block parked. The lock byte never regains a 1. A write happens only on a strobe at an in-range address. The address changes only by being loaded or by stepping up one from an in-range value.

Other behaviours can only be shown by the directed scenarios. These are the CRC values, both the three-byte-prefixed first CRC and the address-seeded continuation CRCs. They also include the AND result of reprogramming, the readback without a strobe, page locking through a status write, and the all-ones readback with a frozen address past the end of each array.

// File: rtl/otpw_pkg.sv
package otpw_pkg;

  localparam int ADDR_W = 16;

  localparam logic [7:0] CMD_WR_DATA = 8'h0F;
  localparam logic [7:0] CMD_WR_STAT = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALO, ST_AHI, ST_DATA, ST_CRC, ST_PROG, ST_VFY, ST_SKIP
  } seq_st_t;

  // CRC-8, x^8+x^5+x^4+1, reflected, LSB of the data first
  function automatic logic [7:0] crc8_step(input logic [7:0] c_in, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/otpw_crc.sv
module otpw_crc
  import otpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] seed,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  always_ff @(posedge clk) begin
    if (rst)      crc <= 8'h00;
    else if (ld)  crc <= seed;
    else if (upd) crc <= crc8_step(crc, din);
  end

endmodule

// File: rtl/otpw_ram.sv
module otpw_ram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // erased state of the array
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/otpw_status.sv
module otpw_status #(
  parameter int NBYTES = 8,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    lock_n
);

  logic [7:0] regs [NBYTES];

  initial begin
    for (int i = 0; i < NBYTES; i++) regs[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) regs[addr] <= wdata;
  end

  assign rdata  = regs[addr];
  assign lock_n = regs[0];

endmodule

// File: rtl/otpw_seq.sv
module otpw_seq
  import otpw_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  input  logic       prog_strobe,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);

  localparam int DATA_DEPTH = PAGES * PAGE_BYTES;
  localparam int DA_W       = $clog2(DATA_DEPTH);
  localparam int PG_W       = $clog2(PAGE_BYTES);
  localparam int SA_W       = $clog2(STAT_BYTES);
  localparam logic [ADDR_W-1:0] DATA_LIM = ADDR_W'(DATA_DEPTH);
  localparam logic [ADDR_W-1:0] STAT_LIM = ADDR_W'(STAT_BYTES);

  seq_st_t           st_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic              is_stat_q;
  logic [7:0]        dbyte_q, vbyte_q;
  logic [7:0]        crc_q, crc_seed;
  logic [7:0]        ram_rd, stat_rd, lock_n, cur_byte, new_byte;
  logic              in_rng, locked, prog_ok, adv, ram_we, stat_we, crc_ld, crc_upd;

  assign in_rng   = is_stat_q ? (addr_q < STAT_LIM) : (addr_q < DATA_LIM);
  assign locked   = !is_stat_q && !lock_n[addr_q[DA_W-1:PG_W]];
  assign cur_byte = !in_rng ? 8'hFF : (is_stat_q ? stat_rd : ram_rd);
  assign new_byte = cur_byte & dbyte_q;
  assign prog_ok  = (st_q == ST_PROG) && prog_strobe && !bus_reset && in_rng && !locked;
  assign ram_we   = prog_ok && !is_stat_q;
  assign stat_we  = prog_ok && is_stat_q;
  assign adv      = !bus_reset && tx_req &&
                    (((st_q == ST_PROG) && !prog_strobe) || (st_q == ST_VFY));
  assign addr_nxt = in_rng ? addr_q + 1'b1 : addr_q;

  assign crc_ld   = bus_reset || adv;
  assign crc_seed = bus_reset ? 8'h00 : addr_nxt[7:0];
  assign crc_upd  = rx_valid && ((st_q == ST_IDLE) || (st_q == ST_ALO) ||
                                 (st_q == ST_AHI)  || (st_q == ST_DATA));

  otpw_crc u_crc (
    .clk (clk), .rst (rst), .ld (crc_ld), .seed (crc_seed),
    .upd (crc_upd), .din (rx_byte), .crc (crc_q)
  );

  otpw_ram #(.DEPTH(DATA_DEPTH)) u_ram (
    .clk (clk), .we (ram_we), .addr (addr_q[DA_W-1:0]),
    .wdata (new_byte), .rdata (ram_rd)
  );

  otpw_status #(.NBYTES(STAT_BYTES)) u_stat (
    .clk (clk), .we (stat_we), .addr (addr_q[SA_W-1:0]),
    .wdata (new_byte), .rdata (stat_rd), .lock_n (lock_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      is_stat_q <= 1'b0;
      dbyte_q   <= 8'hFF;
      vbyte_q   <= 8'hFF;
      tx_valid  <= 1'b0;
      tx_byte   <= 8'h00;
    end else begin
      tx_valid <= 1'b0;
      if (bus_reset) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (rx_valid) begin
            if (rx_byte == CMD_WR_DATA) begin
              is_stat_q <= 1'b0;
              st_q      <= ST_ALO;
            end else if (rx_byte == CMD_WR_STAT) begin
              is_stat_q <= 1'b1;
              st_q      <= ST_ALO;
            end else begin
              st_q      <= ST_SKIP;
            end
          end
          ST_ALO: if (rx_valid) begin
            addr_q[7:0] <= rx_byte;
            st_q        <= ST_AHI;
          end
          ST_AHI: if (rx_valid) begin
            addr_q[15:8] <= rx_byte;
            st_q         <= ST_DATA;
          end
          ST_DATA: if (rx_valid) begin
            dbyte_q <= rx_byte;
            st_q    <= ST_CRC;
          end
          ST_CRC: if (tx_req) begin
            tx_valid <= 1'b1;
            tx_byte  <= crc_q;
            st_q     <= ST_PROG;
          end
          ST_PROG: begin
            if (prog_strobe) begin
              vbyte_q <= prog_ok ? new_byte : cur_byte;
              st_q    <= ST_VFY;
            end else if (tx_req) begin
              tx_valid <= 1'b1;
              tx_byte  <= cur_byte;
              addr_q   <= addr_nxt;
              st_q     <= ST_DATA;
            end
          end
          ST_VFY: if (tx_req) begin
            tx_valid <= 1'b1;
            tx_byte  <= vbyte_q;
            addr_q   <= addr_nxt;
            st_q     <= ST_DATA;
          end
          default: st_q <= ST_SKIP;
        endcase
      end
    end
  end

endmodule

// File: rtl/otpw_seq_chk.sv
module otpw_seq_chk
  import otpw_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_reset,
  input logic        tx_req,
  input logic        prog_strobe,
  input logic        tx_valid,
  input seq_st_t     st_q,
  input logic [15:0] addr_q,
  input logic        in_rng,
  input logic        ram_we,
  input logic        stat_we,
  input logic [7:0]  lock_n
);

  assert_resp_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

  assert_abort_silences_R9: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !tx_valid);

  assert_unknown_cmd_parks_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SKIP) && !bus_reset |=> (st_q == ST_SKIP));

  assert_lock_bits_no_rise_R11: assert property (@(posedge clk) disable iff (rst)
    (lock_n & ~$past(lock_n)) == 8'h00);

  assert_write_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (ram_we || stat_we) |-> (prog_strobe && (st_q == ST_PROG) && in_rng));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_q) |-> (($past(st_q) == ST_ALO) || ($past(st_q) == ST_AHI) ||
                          ((addr_q == $past(addr_q) + 16'd1) && $past(in_rng))));

endmodule

bind otpw_seq otpw_seq_chk u_chk (
  .clk (clk), .rst (rst), .bus_reset (bus_reset), .tx_req (tx_req),
  .prog_strobe (prog_strobe), .tx_valid (tx_valid), .st_q (st_q),
  .addr_q (addr_q), .in_rng (in_rng), .ram_we (ram_we), .stat_we (stat_we),
  .lock_n (lock_n)
);

// File: tb/test_otpw_seq.sv
module test_otpw_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_req = 1'b0;
  logic       prog_strobe = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] m_addr;
  logic [7:0]  m_crc;
  logic        m_stat;

  always #2.5 clk = ~clk;

  otpw_seq i_otpw_seq (
    .clk (clk), .rst (rst), .bus_reset (bus_reset), .rx_valid (rx_valid),
    .rx_byte (rx_byte), .tx_req (tx_req), .prog_strobe (prog_strobe),
    .tx_valid (tx_valid), .tx_byte (tx_byte)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] c_in, input logic [7:0] d);
    logic [7:0] c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic get_byte(output logic v, output logic [7:0] b);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    v = tx_valid; b = tx_byte;
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic pulse_strobe();
    @(negedge clk); prog_strobe = 1'b1;
    @(negedge clk); prog_strobe = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] cmd, input logic [15:0] a);
    pulse_bus_reset();
    send_byte(cmd);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    m_addr = a;
    m_stat = (cmd == 8'h55);
    m_crc  = ref_crc(ref_crc(ref_crc(8'h00, cmd), a[7:0]), a[15:8]);
  endtask

  // one data byte: CRC check (R2 first byte, R6 later), optional strobe, readback check
  task automatic wr_step(input logic [7:0] d, input bit strobe, input logic [7:0] exp_rb,
                         input bit first, input string req);
    logic v; logic [7:0] b; logic [7:0] e;
    send_byte(d);
    e = ref_crc(m_crc, d);
    get_byte(v, b);
    chk(v && b == e, first ? "R2 first CRC" : "R6 continued CRC", b, e);
    if (strobe) pulse_strobe();
    get_byte(v, b);
    chk(v && b == exp_rb, req, b, exp_rb);
    if (m_addr < (m_stat ? 16'd8 : 16'd128)) m_addr = m_addr + 16'd1;
    m_crc = m_addr[7:0];
  endtask

  task automatic t_reset();
    chk(tx_valid == 1'b0, "R10 reset tx_valid", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_basic();
    start_cmd(8'h0F, 16'h0005);
    wr_step(8'hA5, 1, 8'hA5, 1, "R3 R4 program and readback");
    wr_step(8'h3C, 1, 8'h3C, 0, "R6 next address written");
  endtask

  task automatic t_and();
    start_cmd(8'h0F, 16'h0005);
    wr_step(8'h0F, 1, 8'h05, 1, "R3 R11 AND with old byte");
  endtask

  task automatic t_nostrobe();
    start_cmd(8'h0F, 16'h0010);
    wr_step(8'h00, 0, 8'hFF, 1, "R5 no strobe readback");
    start_cmd(8'h0F, 16'h0010);
    wr_step(8'hFF, 1, 8'hFF, 1, "R5 byte left unwritten");
  endtask

  task automatic t_lock();
    start_cmd(8'h55, 16'h0000);
    wr_step(8'hFE, 1, 8'hFE, 1, "R7 status lock write");
    start_cmd(8'h0F, 16'h0007);
    wr_step(8'h00, 1, 8'hFF, 1, "R7 locked page unchanged");
    start_cmd(8'h0F, 16'h0020);
    wr_step(8'h00, 1, 8'h00, 1, "R7 unlocked page written");
  endtask

  task automatic t_range();
    start_cmd(8'h0F, 16'h007F);
    wr_step(8'h12, 1, 8'h12, 1, "R3 last data byte");
    wr_step(8'h34, 1, 8'hFF, 0, "R8 past end reads FF");
    wr_step(8'h56, 1, 8'hFF, 0, "R8 address frozen");
    start_cmd(8'h55, 16'h0008);
    wr_step(8'h00, 1, 8'hFF, 1, "R8 status past end");
  endtask

  task automatic t_abort();
    logic v; logic [7:0] b;
    start_cmd(8'h0F, 16'h0030);
    send_byte(8'h00);
    pulse_bus_reset();
    pulse_strobe();
    get_byte(v, b);
    chk(v == 1'b0, "R9 no response after abort", {7'd0, v}, 8'h00);
    start_cmd(8'h0F, 16'h0030);
    wr_step(8'hFF, 1, 8'hFF, 1, "R9 aborted byte not written");
  endtask

  task automatic t_badcmd();
    logic v; logic [7:0] b;
    pulse_bus_reset();
    send_byte(8'hF0);
    send_byte(8'h01);
    send_byte(8'h00);
    send_byte(8'h00);
    get_byte(v, b);
    chk(v == 1'b0, "R1 unknown command silent", {7'd0, v}, 8'h00);
    pulse_strobe();
    get_byte(v, b);
    chk(v == 1'b0, "R1 R10 still silent", {7'd0, v}, 8'h00);
    start_cmd(8'h55, 16'h0001);
    wr_step(8'hF7, 1, 8'hF7, 1, "R1 status command after reset");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_and();
    t_nostrobe();
    t_lock();
    t_range();
    t_abort();
    t_badcmd();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule